// File: doc/BRIEF.md
# Multi-Mode Floating-Point Result Rounder

This combinational block finishes a binary floating-point result after the sum has been normalised. It receives the sign, the biased exponent field and the stored fraction, plus the three bits below the fraction (guard, round, sticky). It also receives a 3-bit rounding-mode code and three condition flags from the stages before it: overflow, underflow and exact cancellation. A further flag marks the case where both operands were zeros of the same sign.

The control half decides whether the fraction is incremented. It also decides which kind of word leaves the block. The datapath half performs the increment and carries it into the exponent. It then packs one of the following: the rounded value, infinity, the largest finite magnitude, zero, the smallest denormal, or a signed zero. Seven modes are supported: nearest-even, toward zero, toward +inf, toward -inf, nearest-away, and two round-to-odd variants. The two round-to-odd variants differ only in the sign they give a cancelled zero. Each mode has its own rule for what overflow and underflow produce.

Top module: `round_unit`

## Requirements
- R1: The mode code `mode` decodes as 000 nearest-even, 001 toward zero, 010 toward +inf, 011 toward -inf, 100 nearest-away, 101 odd with positive zeros, 110 odd with negative zeros. Code 111 behaves exactly as 000. With all inputs low the result is all zeros.
- R2: In nearest-even mode the fraction is incremented when guard is set and at least one of round, sticky or the fraction LSB is set.
- R3: Toward-zero mode never increments the fraction. Nearest-away mode increments whenever guard is set.
- R4: Toward +inf increments when sign is 0 and any of guard, round or sticky is set. Toward -inf increments when sign is 1 and any of those bits is set.
- R5: Both odd modes increment only when the fraction LSB is 0 and any of guard, round or sticky is set.
- R6: A fraction increment that carries out of the field leaves the fraction at zero and adds one to the exponent field. This also applies from exponent 0 (denormal to smallest normal). If the exponent field becomes all ones, the overflow rule of R7 applies.
- R7: On overflow, the result is infinity (exponent all ones, fraction 0) with the input sign in these cases: nearest-even, nearest-away, toward +inf with sign 0, and toward -inf with sign 1. In every other case the result is the largest finite value of that sign (exponent all ones minus one, fraction all ones).
- R8: On underflow, the result is a zero of the input sign in these cases: nearest-even, toward zero, nearest-away, toward +inf with sign 1, and toward -inf with sign 0. In every other case, including both odd modes, the result is the smallest denormal (exponent 0, fraction 1) of the input sign.
- R9: On exact cancellation the result is a zero whose sign bit is 1 only in toward -inf and odd-with-negative-zeros modes. The input sign is ignored.
- R10: When `keepZero` is set the result is a zero carrying the input sign, whatever the mode. Priority is keepZero, then exactZero, then ovfIn, then unfIn, then rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sign | input | 1 | Result sign, 1 = negative |
| expIn | input | EXP_W | Biased exponent field of the normalised result |
| fracIn | input | FRAC_W | Stored fraction before rounding |
| guardBit | input | 1 | First bit below the fraction LSB |
| roundBit | input | 1 | Second bit below the fraction LSB |
| stickyBit | input | 1 | OR of all lower discarded bits |
| mode | input | 3 | Rounding-mode code (see R1) |
| ovfIn | input | 1 | Result magnitude too large before rounding |
| unfIn | input | 1 | Result magnitude too small to represent |
| exactZero | input | 1 | Exact cancellation produced a zero of undetermined sign |
| keepZero | input | 1 | Both operands were zeros of the same sign |
| result | output | 1+EXP_W+FRAC_W | Packed final word {sign, exponent, fraction} |

## Verification
The block holds no state. A fault in its decisions appears on `result` in the same evaluation: a wrong increment decision, a wrong saturation choice or a wrong zero sign each changes at least the fraction LSB, the exponent field or the sign bit. The most telling stimuli sit at the edges of the increment rule and at the top of the exponent range. These are ties with an even or odd LSB, an all-ones fraction with a carry, and the exponent one step below all ones. Each of the two signs is applied under every mode there.

// File: rtl/round_pkg.sv
package round_pkg;

  typedef enum logic [2:0] {
    RM_EVEN  = 3'b000,
    RM_ZERO  = 3'b001,
    RM_UP    = 3'b010,
    RM_DOWN  = 3'b011,
    RM_AWAY  = 3'b100,
    RM_ODDP  = 3'b101,
    RM_ODDN  = 3'b110
  } rmode_e;

  // strobes from control to datapath: exactly one sel* is high
  typedef struct packed {
    logic selKeep;
    logic selCancel;
    logic selInf;
    logic selMaxNorm;
    logic selZero;
    logic selMinDen;
    logic selRound;
    logic cancelNeg;
  } pick_t;

endpackage

// File: rtl/round_ctrl.sv
module round_ctrl
  import round_pkg::*;
(
  input  logic        sign,
  input  logic        fracLsb,
  input  logic        guardBit,
  input  logic        roundBit,
  input  logic        stickyBit,
  input  logic [2:0]  mode,
  input  logic        ovfIn,
  input  logic        unfIn,
  input  logic        exactZero,
  input  logic        keepZero,
  input  logic        roundOvf,
  output logic        incr,
  output pick_t       pick
);

  rmode_e rm;
  logic   anyLow;
  logic   ovfToInf;
  logic   unfToZero;
  logic   anyOvf;

  always_comb begin
    case (mode)
      3'b001:  rm = RM_ZERO;
      3'b010:  rm = RM_UP;
      3'b011:  rm = RM_DOWN;
      3'b100:  rm = RM_AWAY;
      3'b101:  rm = RM_ODDP;
      3'b110:  rm = RM_ODDN;
      default: rm = RM_EVEN;
    endcase
  end

  assign anyLow = guardBit | roundBit | stickyBit;

  always_comb begin
    case (rm)
      RM_EVEN:          incr = guardBit & (roundBit | stickyBit | fracLsb);
      RM_ZERO:          incr = 1'b0;
      RM_UP:            incr = ~sign & anyLow;
      RM_DOWN:          incr = sign & anyLow;
      RM_AWAY:          incr = guardBit;
      RM_ODDP, RM_ODDN: incr = ~fracLsb & anyLow;
      default:          incr = 1'b0;
    endcase
  end

  always_comb begin
    case (rm)
      RM_EVEN, RM_AWAY: begin ovfToInf = 1'b1;  unfToZero = 1'b1;  end
      RM_ZERO:          begin ovfToInf = 1'b0;  unfToZero = 1'b1;  end
      RM_UP:            begin ovfToInf = ~sign; unfToZero = sign;  end
      RM_DOWN:          begin ovfToInf = sign;  unfToZero = ~sign; end
      default:          begin ovfToInf = 1'b0;  unfToZero = 1'b0;  end
    endcase
  end

  assign anyOvf = ovfIn | (roundOvf & ~unfIn);

  always_comb begin
    pick = '0;
    pick.cancelNeg = (rm == RM_DOWN) || (rm == RM_ODDN);
    if (keepZero)                 pick.selKeep    = 1'b1;
    else if (exactZero)           pick.selCancel  = 1'b1;
    else if (ovfIn)               pick.selInf     = ovfToInf;
    else if (unfIn)               pick.selZero    = unfToZero;
    else if (roundOvf)            pick.selInf     = ovfToInf;
    else                          pick.selRound   = 1'b1;
    if (!keepZero && !exactZero) begin
      if (anyOvf)                 pick.selMaxNorm = ~ovfToInf;
      else if (unfIn)             pick.selMinDen  = ~unfToZero;
    end
  end

  always_comb begin
    AST_ONE_PICK: assert ($onehot({pick.selKeep, pick.selCancel, pick.selInf,
      pick.selMaxNorm, pick.selZero, pick.selMinDen, pick.selRound})); // R10
    if (mode == 3'b001)
      AST_RTZ_HOLD: assert (!incr); // R3
    if ((mode == 3'b101 || mode == 3'b110) && incr)
      AST_ODD_FROM_EVEN: assert (!fracLsb); // R5
    if (pick.selInf)
      AST_INF_MODE: assert (mode != 3'b001 && mode != 3'b101 && mode != 3'b110); // R7
    if (pick.selZero)
      AST_FLUSH_MODE: assert (mode != 3'b101 && mode != 3'b110); // R8
  end

endmodule

// File: rtl/round_dp.sv
module round_dp
  import round_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                      sign,
  input  logic [EXP_W-1:0]          expIn,
  input  logic [FRAC_W-1:0]         fracIn,
  input  logic                      incr,
  input  pick_t                     pick,
  output logic                      roundOvf,
  output logic [EXP_W+FRAC_W:0]     result
);

  localparam logic [EXP_W-1:0]  EXP_ONES = '1;
  localparam logic [EXP_W-1:0]  EXP_MAXN = EXP_ONES - 1'b1;
  localparam logic [FRAC_W-1:0] FRAC_ONE = FRAC_W'(1);

  logic [FRAC_W:0]    fracSum;
  logic               carry;
  logic [FRAC_W-1:0]  fracR;
  logic [EXP_W-1:0]   expR;

  assign fracSum  = {1'b0, fracIn} + {{FRAC_W{1'b0}}, incr};
  assign carry    = fracSum[FRAC_W];
  assign fracR    = fracSum[FRAC_W-1:0];
  assign expR     = expIn + {{(EXP_W-1){1'b0}}, carry};
  assign roundOvf = (expR == EXP_ONES) || (expIn == EXP_ONES);

  always_comb begin
    result = '0;
    case (1'b1)
      pick.selKeep:    result = {sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
      pick.selCancel:  result = {pick.cancelNeg, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
      pick.selInf:     result = {sign, EXP_ONES, {FRAC_W{1'b0}}};
      pick.selMaxNorm: result = {sign, EXP_MAXN, {FRAC_W{1'b1}}};
      pick.selZero:    result = {sign, {EXP_W{1'b0}}, {FRAC_W{1'b0}}};
      pick.selMinDen:  result = {sign, {EXP_W{1'b0}}, FRAC_ONE};
      default:         result = {sign, expR, fracR};
    endcase
  end

  always_comb begin
    if (pick.selRound)
      AST_ROUND_FINITE: assert (result[EXP_W+FRAC_W-1:FRAC_W] != EXP_ONES); // R6
    if (pick.selRound && incr && fracIn == {FRAC_W{1'b1}})
      AST_CARRY_WRAP: assert (result[FRAC_W-1:0] == '0
                              && result[EXP_W+FRAC_W-1:FRAC_W] == expIn + 1'b1); // R6
  end

endmodule

// File: rtl/round_unit.sv
module round_unit
  import round_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic               sign,
  input  logic [EXP_W-1:0]   expIn,
  input  logic [FRAC_W-1:0]  fracIn,
  input  logic               guardBit,
  input  logic               roundBit,
  input  logic               stickyBit,
  input  logic [2:0]         mode,
  input  logic               ovfIn,
  input  logic               unfIn,
  input  logic               exactZero,
  input  logic               keepZero,
  output logic [WORD_W-1:0]  result
);

  logic  incr;
  logic  roundOvf;
  pick_t pick;

  round_ctrl uCtrl (
    .sign      (sign),
    .fracLsb   (fracIn[0]),
    .guardBit  (guardBit),
    .roundBit  (roundBit),
    .stickyBit (stickyBit),
    .mode      (mode),
    .ovfIn     (ovfIn),
    .unfIn     (unfIn),
    .exactZero (exactZero),
    .keepZero  (keepZero),
    .roundOvf  (roundOvf),
    .incr      (incr),
    .pick      (pick)
  );

  round_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uDp (
    .sign     (sign),
    .expIn    (expIn),
    .fracIn   (fracIn),
    .incr     (incr),
    .pick     (pick),
    .roundOvf (roundOvf),
    .result   (result)
  );

endmodule

// File: tb/tb_round_unit.sv
module tb_round_unit;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        sign, guardBit, roundBit, stickyBit, ovfIn, unfIn, exactZero, keepZero;
  logic [7:0]  expIn;
  logic [22:0] fracIn;
  logic [2:0]  mode;
  logic [31:0] result;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  round_unit dut (
    .sign(sign), .expIn(expIn), .fracIn(fracIn), .guardBit(guardBit),
    .roundBit(roundBit), .stickyBit(stickyBit), .mode(mode), .ovfIn(ovfIn),
    .unfIn(unfIn), .exactZero(exactZero), .keepZero(keepZero), .result(result)
  );

  task automatic apply(input logic [2:0] m, input logic s, input logic [7:0] e,
                       input logic [22:0] f, input logic [2:0] grs,
                       input logic [3:0] flags);
    @(negedge clk);
    mode = m; sign = s; expIn = e; fracIn = f;
    {guardBit, roundBit, stickyBit} = grs;
    {ovfIn, unfIn, exactZero, keepZero} = flags;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] expV);
    nChecks++;
    if (result !== expV) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, result, expV);
    end
  endtask

  task automatic t_reset;
    apply(3'b000, 0, 8'h00, 23'h0, 3'b000, 4'b0000); chk("R1 idle", 32'h0000_0000);
  endtask

  task automatic t_even;
    apply(3'b000, 0, 8'h7F, 23'h0, 3'b100, 4'b0); chk("R2 tie even lsb", 32'h3F80_0000);
    apply(3'b000, 0, 8'h7F, 23'h1, 3'b100, 4'b0); chk("R2 tie odd lsb", 32'h3F80_0002);
    apply(3'b000, 0, 8'h7F, 23'h0, 3'b101, 4'b0); chk("R2 above half", 32'h3F80_0001);
    apply(3'b000, 0, 8'h7F, 23'h1, 3'b011, 4'b0); chk("R2 below half", 32'h3F80_0001);
    apply(3'b111, 0, 8'h7F, 23'h1, 3'b100, 4'b0); chk("R1 code7 as even", 32'h3F80_0002);
    apply(3'b111, 0, 8'h7F, 23'h0, 3'b100, 4'b0); chk("R1 code7 tie even", 32'h3F80_0000);
  endtask

  task automatic t_zero_away;
    apply(3'b001, 0, 8'h7F, 23'h0, 3'b111, 4'b0); chk("R3 toward zero", 32'h3F80_0000);
    apply(3'b001, 1, 8'h7F, 23'h1, 3'b111, 4'b0); chk("R3 toward zero neg", 32'hBF80_0001);
    apply(3'b100, 0, 8'h7F, 23'h0, 3'b100, 4'b0); chk("R3 away tie", 32'h3F80_0001);
    apply(3'b100, 0, 8'h7F, 23'h0, 3'b011, 4'b0); chk("R3 away below", 32'h3F80_0000);
  endtask

  task automatic t_directed;
    apply(3'b010, 0, 8'h7F, 23'h0, 3'b001, 4'b0); chk("R4 up pos", 32'h3F80_0001);
    apply(3'b010, 1, 8'h7F, 23'h0, 3'b001, 4'b0); chk("R4 up neg", 32'hBF80_0000);
    apply(3'b011, 1, 8'h7F, 23'h0, 3'b001, 4'b0); chk("R4 down neg", 32'hBF80_0001);
    apply(3'b011, 0, 8'h7F, 23'h0, 3'b001, 4'b0); chk("R4 down pos", 32'h3F80_0000);
    apply(3'b010, 0, 8'h7F, 23'h0, 3'b000, 4'b0); chk("R4 up exact", 32'h3F80_0000);
  endtask

  task automatic t_odd;
    apply(3'b101, 0, 8'h7F, 23'h0, 3'b001, 4'b0); chk("R5 oddp even lsb", 32'h3F80_0001);
    apply(3'b101, 0, 8'h7F, 23'h1, 3'b100, 4'b0); chk("R5 oddp odd lsb", 32'h3F80_0001);
    apply(3'b101, 0, 8'h7F, 23'h2, 3'b000, 4'b0); chk("R5 oddp exact", 32'h3F80_0002);
    apply(3'b110, 1, 8'h7F, 23'h2, 3'b010, 4'b0); chk("R5 oddn even lsb", 32'hBF80_0003);
    apply(3'b110, 1, 8'h7F, 23'h3, 3'b111, 4'b0); chk("R5 oddn odd lsb", 32'hBF80_0003);
  endtask

  task automatic t_carry;
    apply(3'b010, 0, 8'h7F, 23'h7FFFFF, 3'b100, 4'b0); chk("R6 carry", 32'h4000_0000);
    apply(3'b000, 0, 8'h00, 23'h7FFFFF, 3'b110, 4'b0); chk("R6 denorm carry", 32'h0080_0000);
    apply(3'b000, 0, 8'hFE, 23'h7FFFFF, 3'b110, 4'b0); chk("R6 carry to inf", 32'h7F80_0000);
    apply(3'b100, 1, 8'hFE, 23'h7FFFFF, 3'b100, 4'b0); chk("R6 away carry inf", 32'hFF80_0000);
    apply(3'b001, 0, 8'hFE, 23'h7FFFFF, 3'b111, 4'b0); chk("R6 rtz no carry", 32'h7F7F_FFFF);
    apply(3'b101, 0, 8'hFE, 23'h7FFFFF, 3'b111, 4'b0); chk("R6 odd no carry", 32'h7F7F_FFFF);
  endtask

  task automatic t_ovf;
    apply(3'b000, 0, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 even", 32'h7F80_0000);
    apply(3'b001, 1, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 rtz", 32'hFF7F_FFFF);
    apply(3'b010, 0, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 up pos", 32'h7F80_0000);
    apply(3'b010, 1, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 up neg", 32'hFF7F_FFFF);
    apply(3'b011, 1, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 down neg", 32'hFF80_0000);
    apply(3'b011, 0, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 down pos", 32'h7F7F_FFFF);
    apply(3'b100, 1, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 away", 32'hFF80_0000);
    apply(3'b101, 0, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 oddp", 32'h7F7F_FFFF);
    apply(3'b110, 1, 8'hFF, 23'h0, 3'b000, 4'b1000); chk("R7 oddn", 32'hFF7F_FFFF);
  endtask

  task automatic t_unf;
    apply(3'b000, 0, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 even", 32'h0000_0000);
    apply(3'b001, 1, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 rtz", 32'h8000_0000);
    apply(3'b010, 0, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 up pos", 32'h0000_0001);
    apply(3'b010, 1, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 up neg", 32'h8000_0000);
    apply(3'b011, 1, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 down neg", 32'h8000_0001);
    apply(3'b011, 0, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 down pos", 32'h0000_0000);
    apply(3'b100, 0, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 away", 32'h0000_0000);
    apply(3'b101, 1, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 oddp", 32'h8000_0001);
    apply(3'b110, 0, 8'h00, 23'h0, 3'b011, 4'b0100); chk("R8 oddn", 32'h0000_0001);
  endtask

  task automatic t_cancel;
    apply(3'b000, 1, 8'h00, 23'h0, 3'b000, 4'b0010); chk("R9 even", 32'h0000_0000);
    apply(3'b011, 0, 8'h00, 23'h0, 3'b000, 4'b0010); chk("R9 down", 32'h8000_0000);
    apply(3'b110, 0, 8'h00, 23'h0, 3'b000, 4'b0010); chk("R9 oddn", 32'h8000_0000);
    apply(3'b101, 1, 8'h00, 23'h0, 3'b000, 4'b0010); chk("R9 oddp", 32'h0000_0000);
    apply(3'b010, 1, 8'h00, 23'h0, 3'b000, 4'b0010); chk("R9 up", 32'h0000_0000);
    apply(3'b111, 1, 8'h00, 23'h0, 3'b000, 4'b0010); chk("R9 code7", 32'h0000_0000);
  endtask

  task automatic t_keep;
    apply(3'b010, 1, 8'h00, 23'h0, 3'b000, 4'b0001); chk("R10 keep neg", 32'h8000_0000);
    apply(3'b011, 0, 8'h00, 23'h0, 3'b000, 4'b0001); chk("R10 keep pos", 32'h0000_0000);
    apply(3'b110, 0, 8'hFF, 23'h0, 3'b111, 4'b1111); chk("R10 keep first", 32'h0000_0000);
    apply(3'b011, 0, 8'hFF, 23'h0, 3'b000, 4'b1110); chk("R10 cancel over ovf", 32'h8000_0000);
    apply(3'b000, 1, 8'h00, 23'h0, 3'b000, 4'b1100); chk("R10 ovf over unf", 32'hFF80_0000);
  endtask

  initial begin
    fork
      begin
        sign = 0; expIn = '0; fracIn = '0; {guardBit, roundBit, stickyBit} = '0;
        mode = '0; {ovfIn, unfIn, exactZero, keepZero} = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset();
        t_even();
        t_zero_away();
        t_directed();
        t_odd();
        t_carry();
        t_ovf();
        t_unf();
        t_cancel();
        t_keep();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          nChecks++;
          nFails++;
          $display("FAIL watchdog: got hung expected done");
        end
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule